// File: doc/BRIEF.md
# Machine-Cycle Clock Rate Selector

This block produces the machine-cycle enable strobe for a processor core. It runs from a reference clock `clk_i` that an ideal frequency multiplier delivers at four times the oscillator rate, so one oscillator cycle is four `clk_i` cycles. A 3-bit mode word `{mult_sel, cd1, cd0}` selects how many oscillator cycles make one machine cycle: a quarter, a half, one, or 1024. The two fast rates also need the multiplier to be enabled and locked. The block emits `tick_o`, high for exactly one `clk_i` cycle at the end of every machine cycle. It also emits a status bit telling whether a multiplied rate is the one actually in effect.

A rate change never cuts a machine cycle short. The mode word, the enable and the lock flag are taken into account only on the clock edge that closes a tick. The machine cycle in progress always finishes at the length it started with.

Top module: `mc_rate_sel`

## Requirements
- R1: While reset is held, `tick_o` and `mult_active_o` are 0. After reset the rate is one oscillator cycle per machine cycle, which is one tick every 4 `clk_i` cycles, and `mult_active_o` is 0.
- R2: Mode word 3'b100 (`mode_i[2]`=1, `mode_i[1:0]`=00) with `mult_en_i`=1 and `mult_lock_i`=1 gives one tick every `clk_i` cycle, and `mult_active_o` is 1.
- R3: Mode word 3'b000 with `mult_en_i`=1 and `mult_lock_i`=1 gives one tick every 2 `clk_i` cycles, and `mult_active_o` is 1.
- R4: When `mode_i[1:0]`=10, the rate is one tick every 4 `clk_i` cycles whatever `mode_i[2]` holds, and `mult_active_o` is 0.
- R5: When `mode_i[1:0]`=11, the rate is one tick every 4096 `clk_i` cycles (1024 oscillator cycles) whatever `mode_i[2]` holds, and `mult_active_o` is 0.
- R6: The reserved code `mode_i[1:0]`=01 behaves as one tick every 4 `clk_i` cycles, with `mult_active_o` 0, for either value of `mode_i[2]`.
- R7: When `mode_i[1:0]`=00 and either `mult_en_i` or `mult_lock_i` is 0, the block falls back to one tick every 4 `clk_i` cycles and `mult_active_o` is 0. This includes the lock dropping while a multiplied rate is running.
- R8: Inputs are sampled only on the edge that ends a tick cycle. A change made inside a machine cycle lets that cycle finish at its old length and applies from the next one. `mult_active_o` changes only at that boundary.
- R9: The 1024-step slow divider restarts from zero whenever the slow rate is entered, so the first slow machine cycle is a full 4096 `clk_i` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock at four times the oscillator rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Mode word {mult_sel, cd1, cd0} |
| mult_en_i | input | 1 | Multiplier enable control |
| mult_lock_i | input | 1 | Multiplier lock flag from the multiplier model |
| tick_o | output | 1 | One-cycle strobe in the last `clk_i` cycle of each machine cycle |
| mult_active_o | output | 1 | 1 while a multiplied rate (4x or 2x) is in effect |

## Verification
The hardest cases to reach are mode changes that arrive partway through a machine cycle, above all partway through the 4096-cycle slow period. These are the cases that show whether the old period is kept whole and whether the slow divider restarts cleanly. The driver counts ticks at the ports and then waits a chosen number of cycles inside the current period before it changes the inputs. For each change it queues one entry for the old period and then entries for the new one. The monitor measures every tick-to-tick interval against that queue. The same skewed changes are used to drop the lock during the 2x rate, to enter the slow rate from a mid-period 1x setting, and to leave it halfway through a slow period.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  // Reference clock cycles per oscillator cycle (ideal 4x multiplier output)
  localparam int REF_PER_OSC = 4;
  localparam int PRE_W       = $clog2(REF_PER_OSC);

  typedef enum logic [1:0] {
    RATE_X4   = 2'd0,
    RATE_X2   = 2'd1,
    RATE_X1   = 2'd2,
    RATE_SLOW = 2'd3
  } rate_e;

  // Last prescaler count of a machine cycle for each rate
  function automatic logic [PRE_W-1:0] pre_limit(rate_e r);
    case (r)
      RATE_X4: pre_limit = PRE_W'(0);
      RATE_X2: pre_limit = PRE_W'(1);
      default: pre_limit = PRE_W'(REF_PER_OSC - 1);
    endcase
  endfunction

endpackage

// File: rtl/mc_reset_sync.sv
module mc_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/mc_rate_decode.sv
module mc_rate_decode
  import mcr_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       mult_en_i,
  input  logic       mult_lock_i,
  output rate_e      rate_nxt_o
);

  logic mult_ok;

  assign mult_ok = mult_en_i & mult_lock_i;

  always_comb begin
    unique case (mode_i[1:0])
      2'b00: begin
        if (mult_ok) rate_nxt_o = mode_i[2] ? RATE_X4 : RATE_X2;
        else         rate_nxt_o = RATE_X1;     // fallback when multiplier unusable
      end
      2'b11:   rate_nxt_o = RATE_SLOW;
      default: rate_nxt_o = RATE_X1;           // 10 and reserved 01
    endcase
  end

endmodule

// File: rtl/mc_period_count.sv
module mc_period_count
  import mcr_pkg::*;
#(
  parameter int SLOW_DIV = 1024
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rate_e rate_nxt_i,
  output logic  tick_o,
  output rate_e rate_o
);

  localparam int                SLOW_W   = $clog2(SLOW_DIV);
  localparam logic [SLOW_W-1:0] SLOW_MAX = SLOW_W'(SLOW_DIV - 1);

  rate_e             rate_q, rate_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [SLOW_W-1:0] slow_q, slow_d;
  logic              pre_last, slow_last, tick;

  assign pre_last  = (pre_q == pre_limit(rate_q));
  assign slow_last = (slow_q == SLOW_MAX);
  assign tick      = pre_last & ((rate_q != RATE_SLOW) | slow_last);

  always_comb begin
    rate_d = rate_q;
    pre_d  = pre_q;
    slow_d = slow_q;
    if (tick) begin
      rate_d = rate_nxt_i;
      pre_d  = '0;
      slow_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
      if ((rate_q == RATE_SLOW) && pre_last) slow_d = slow_q + SLOW_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= RATE_X1;
      pre_q  <= '0;
      slow_q <= '0;
    end else begin
      rate_q <= rate_d;
      pre_q  <= pre_d;
      slow_q <= slow_d;
    end
  end

  assign tick_o = tick;
  assign rate_o = rate_q;

  // R8: rate only moves on the edge closing a tick
  p_rate_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(rate_q));

  // R8: only the 4x rate may produce adjacent ticks
  p_no_b2b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && rate_nxt_i != RATE_X4) |=> !tick);

  // R9: slow divider sits at zero outside the slow rate
  p_slow_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q != RATE_SLOW) |-> (slow_q == '0));

endmodule

// File: rtl/mc_rate_sel.sv
module mc_rate_sel
  import mcr_pkg::*;
#(
  parameter int SLOW_DIV = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       mult_en_i,
  input  logic       mult_lock_i,
  output logic       tick_o,
  output logic       mult_active_o
);

  logic  rst_n_int;
  rate_e rate_nxt, rate_cur;

  mc_reset_sync i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  mc_rate_decode i_decode (
    .mode_i      (mode_i),
    .mult_en_i   (mult_en_i),
    .mult_lock_i (mult_lock_i),
    .rate_nxt_o  (rate_nxt)
  );

  mc_period_count #(.SLOW_DIV(SLOW_DIV)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .rate_nxt_i (rate_nxt),
    .tick_o     (tick_o),
    .rate_o     (rate_cur)
  );

  assign mult_active_o = (rate_cur == RATE_X4) || (rate_cur == RATE_X2);

  // R7: a multiplied rate starts only if enable and lock were both present
  p_active_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $rose(mult_active_o) |-> $past(mult_en_i && mult_lock_i));

  // R6: reserved code never leads to a multiplied rate
  p_reserved_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (tick_o && mode_i[1:0] == 2'b01) |=> !mult_active_o);

endmodule

// File: tb/test_mc_rate_sel.sv
`timescale 1ns/1ps
module test_mc_rate_sel;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic       en, lock;
  logic       tick, active;

  always #2.5 clk = ~clk;

  mc_rate_sel i_mc_rate_sel (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mode_i        (mode),
    .mult_en_i     (en),
    .mult_lock_i   (lock),
    .tick_o        (tick),
    .mult_active_o (active)
  );

  int    n_chk = 0, n_fail = 0;
  int    q_per[$];
  bit    q_act[$];
  string q_tag[$];
  int    cur_per;
  bit    cur_act;
  string cur_tag;
  bit    armed = 1'b0;
  int    cyc = 0;
  bit    done = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: measure each tick-to-tick interval and compare to the queue
  always @(negedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cyc   <= 0;
    end else begin
      if (tick) begin
        if (armed && q_per.size() > 0) begin
          int    p;
          bit    a;
          string t;
          p = q_per.pop_front();
          a = q_act.pop_front();
          t = q_tag.pop_front();
          check(cyc + 1 == p, {t, " period"}, cyc + 1, p);
          check(active == a, {t, " active"}, active, a);
        end
        armed <= 1'b1;
        cyc   <= 0;
      end else begin
        cyc <= cyc + 1;
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) begin
      q_per.push_back(cur_per);
      q_act.push_back(cur_act);
      q_tag.push_back(cur_tag);
    end
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // Change inputs skew cycles after the last tick; old period completes first
  task automatic step(logic [2:0] m, logic e, logic l, int skew,
                      int per, bit a, string tag);
    repeat (skew) @(negedge clk);
    mode = m; en = e; lock = l;
    if (skew > 0) begin
      q_per.push_back(cur_per);
      q_act.push_back(cur_act);
      q_tag.push_back({tag, " old-period"});
    end
    cur_per = per; cur_act = a; cur_tag = tag;
    if (skew > 0) wait_tick();
  endtask

  initial begin
    rst_n = 1'b0; mode = 3'b010; en = 1'b0; lock = 1'b0;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 reset tick", tick, 0);
    check(active == 1'b0, "R1 reset active", active, 0);
    rst_n = 1'b1;
    cur_per = 4; cur_act = 1'b0; cur_tag = "R1";
    wait_tick();
    hold(3);
    step(3'b110, 0, 0, 1, 4, 0, "R4");            hold(2);
    step(3'b000, 1, 1, 2, 2, 1, "R3");            hold(3);
    step(3'b100, 1, 1, 1, 1, 1, "R2");            hold(4);
    step(3'b001, 1, 1, 0, 4, 0, "R6");            hold(2);
    step(3'b101, 1, 1, 3, 4, 0, "R6 sel1");       hold(2);
    step(3'b000, 0, 1, 1, 4, 0, "R7 no-en");      hold(2);
    step(3'b000, 1, 1, 1, 2, 1, "R3 again");      hold(2);
    step(3'b000, 1, 0, 1, 4, 0, "R7 lock-loss");  hold(2);
    step(3'b011, 0, 0, 3, 4096, 0, "R5 R9");      hold(1);
    step(3'b100, 1, 1, 2000, 1, 1, "R8 leave-slow"); hold(3);
    step(3'b111, 1, 1, 0, 4096, 0, "R5 sel1 R9"); hold(1);
    step(3'b010, 0, 0, 100, 4, 0, "R8 R4");       hold(2);
    repeat (2) @(negedge clk);
    check(q_per.size() == 0, "R8 queue drained", q_per.size(), 0);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule